// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This controller gathers a parameterized set of maskable peripheral requests and eight non-maskable trap requests. It turns them into a single request toward a processor, along with the number and program-memory address of the vector word to fetch. Each maskable source has an enable bit, a sticky pending flag and a 3-bit user level. Level 0 keeps a source silent. Traps outrank every maskable source.

The arbitration is combinational and works on the registered flags and settings. The request, vector number, vector address and level outputs are registered. A request goes out only when the winner's level is strictly above the level the processor reports. This lets a more urgent source preempt a running handler. The processor answers with a one-cycle acknowledge, which clears the pending flag of the presented vector and latches it as the granted vector.

A control bit chooses between two vector tables that share one layout but start at different bases. Software reaches the per-source settings through a simple write port with a source index, and can read back each source's state through a read port.

Top module: `pvic_top`

## Requirements
- R1: After reset, irq_o is 0, every source reads back 0 on rd_data_o (flag, enable and level cleared), and the primary table is selected.
- R2: A high cycle on src_req_i[n] sets a sticky pending flag for source n. Writing cfg_sel_i=2 with cfg_data_i[0]=1 clears flag cfg_idx_i. A set and a clear in the same cycle leave the flag set. rd_data_o for source rd_idx_i is {flag, enable, level[2:0]}.
- R3: A maskable source competes only when its flag is set, its enable bit is 1 (written with cfg_sel_i=1, cfg_data_i[0]), and its level is non-zero. While it does not compete, its flag stays pending.
- R4: Among competing maskable sources, the highest level wins (7 is highest). On equal levels, the lowest source index wins.
- R5: Any pending trap outranks all maskable sources whatever their settings, and is presented with level 8. Among traps, the lowest trap index wins. Trap flags are set by trap_req_i and cleared only by acknowledge.
- R6: irq_o is raised only when the winner's level is strictly greater than cpu_lvl_i.
- R7: Trap t has vector number t. Maskable source n has vector number 8+n. vec_addr_o equals base + 2·vector, with base 0x000004 for the primary table (source n at 0x000014+2n) and 0x000104 for the alternate table, which is selected by writing cfg_sel_i=3 with cfg_data_i[0].
- R8: irq_o and the vector outputs appear one clock after the flag edge. A request pulse captured at edge k shows no request after k, and shows the request after edge k+1.
- R9: ack_i high while irq_o is high clears the presented vector's flag, latches grant_num_o and grant_lvl_o, and forces irq_o low for the next cycle. ack_i while irq_o is low changes nothing.
- R10: A level written with cfg_sel_i=0 (cfg_data_i[2:0]) takes effect on the arbitration from the next cycle, so raising a pending source above the processor level starts its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | N_SRC | Maskable request inputs, each sets its flag |
| trap_req_i | input | N_TRAP | Trap request inputs |
| cfg_wr_i | input | 1 | Write strobe for the settings port |
| cfg_sel_i | input | 2 | 0 level, 1 enable, 2 clear flag, 3 table select |
| cfg_idx_i | input | log2(N_SRC) | Source addressed by a write |
| cfg_data_i | input | 3 | Write data |
| rd_idx_i | input | log2(N_SRC) | Source shown on rd_data_o |
| rd_data_o | output | 5 | {flag, enable, level} of source rd_idx_i |
| cpu_lvl_i | input | 4 | Processor's current level |
| irq_o | output | 1 | Request toward the processor |
| vec_num_o | output | log2(N_TRAP+N_SRC) | Vector number presented |
| vec_addr_o | output | ADDR_W | Address of the vector word |
| irq_lvl_o | output | 4 | Level of the presented vector |
| ack_i | input | 1 | One-cycle acknowledge |
| grant_num_o | output | log2(N_TRAP+N_SRC) | Last acknowledged vector number |
| grant_lvl_o | output | 4 | Last acknowledged level |

## Verification
The bench targets equal-level ties, a level equal to the processor level, and traps arriving together with a level-7 source. A design that broke ties toward the higher index, compared with greater-or-equal, or ranked traps as ordinary levels would present the wrong vector or raise a request that should wait. It also drives a set and a clear in the same cycle, an acknowledge while no request is raised, and a pending source whose enable or level is zero. A wrong flag priority, a stray clear or a leaky mask each shows on rd_data_o or irq_o. The alternate table and the one-cycle request latency are also checked, so an addressing or pipeline error appears as a wrong vec_addr_o or an early or late request.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int LVL_W  = 4;
    localparam int PRIO_W = 3;
    localparam logic [LVL_W-1:0] TRAP_LVL = 4'd8;

    typedef enum logic [1:0] {
        SEL_PRIO = 2'd0,
        SEL_EN   = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_ALT  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/pvic_arb.sv
// Combinational winner selection: traps first, then level, then index.
module pvic_arb
    import pvic_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int N_TRAP = 8,
    parameter int VN_W   = 5
) (
    input  logic [N_SRC-1:0]             src_flag,
    input  logic [N_SRC-1:0]             src_en,
    input  logic [N_SRC-1:0][PRIO_W-1:0] src_prio,
    input  logic [N_TRAP-1:0]            trap_flag,
    input  logic [LVL_W-1:0]             cpu_lvl,
    output logic                         win_valid,
    output logic [VN_W-1:0]              win_num,
    output logic [LVL_W-1:0]             win_lvl
);
    logic [PRIO_W-1:0] best_p;
    int                best_i;
    logic              t_found;
    int                t_i;

    always_comb begin
        best_p = '0;
        best_i = 0;
        // strict compare while ascending keeps the lowest index on ties
        for (int i = 0; i < N_SRC; i++) begin
            if (src_flag[i] && src_en[i] && (src_prio[i] > best_p)) begin
                best_p = src_prio[i];
                best_i = i;
            end
        end
        t_found = 1'b0;
        t_i     = 0;
        for (int t = N_TRAP - 1; t >= 0; t--) begin
            if (trap_flag[t]) begin
                t_found = 1'b1;
                t_i     = t;
            end
        end
        if (t_found) begin
            win_num = VN_W'(t_i);
            win_lvl = TRAP_LVL;
        end else if (best_p != '0) begin
            win_num = VN_W'(N_TRAP + best_i);
            win_lvl = {1'b0, best_p};
        end else begin
            win_num = '0;
            win_lvl = '0;
        end
        win_valid = (t_found || (best_p != '0)) && (win_lvl > cpu_lvl);
    end
endmodule

// File: rtl/pvic_addr.sv
// Vector word address from vector number and table select.
module pvic_addr #(
    parameter int              VN_W     = 5,
    parameter int              ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] PRI_BASE = 24'h000004,
    parameter logic [ADDR_W-1:0] ALT_BASE = 24'h000104
) (
    input  logic [VN_W-1:0]   vnum,
    input  logic              alt,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;
    always_comb begin
        base = alt ? ALT_BASE : PRI_BASE;
        addr = base + ADDR_W'({vnum, 1'b0});
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int N_TRAP = 8,
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] PRI_BASE = 24'h000004,
    parameter logic [ADDR_W-1:0] ALT_BASE = 24'h000104,
    localparam int N_VEC = N_TRAP + N_SRC,
    localparam int VN_W  = $clog2(N_VEC),
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req_i,
    input  logic [N_TRAP-1:0] trap_req_i,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [2:0]        cfg_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [4:0]        rd_data_o,
    input  logic [3:0]        cpu_lvl_i,
    output logic              irq_o,
    output logic [VN_W-1:0]   vec_num_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic [3:0]        irq_lvl_o,
    input  logic              ack_i,
    output logic [VN_W-1:0]   grant_num_o,
    output logic [3:0]        grant_lvl_o
);
    typedef struct packed {
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0]             flag;
        logic [N_TRAP-1:0]            tflag;
        logic                         alt;
        logic                         irq;
        logic [VN_W-1:0]              vnum;
        logic [ADDR_W-1:0]            addr;
        logic [LVL_W-1:0]             lvl;
        logic [VN_W-1:0]              gnum;
        logic [LVL_W-1:0]             glvl;
    } st_t;

    st_t st_d, st_q;

    logic              win_valid;
    logic [VN_W-1:0]   win_num;
    logic [LVL_W-1:0]  win_lvl;
    logic [ADDR_W-1:0] win_addr;

    pvic_arb #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .VN_W(VN_W)) u_arb (
        .src_flag  (st_q.flag),
        .src_en    (st_q.en),
        .src_prio  (st_q.prio),
        .trap_flag (st_q.tflag),
        .cpu_lvl   (cpu_lvl_i),
        .win_valid (win_valid),
        .win_num   (win_num),
        .win_lvl   (win_lvl)
    );

    pvic_addr #(.VN_W(VN_W), .ADDR_W(ADDR_W), .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)) u_addr (
        .vnum (win_num),
        .alt  (st_q.alt),
        .addr (win_addr)
    );

    cfg_sel_e          sel;
    logic              ack_take;
    logic [N_SRC-1:0]  clr_src;
    logic [N_TRAP-1:0] clr_trap;
    int                ci;
    int                ri;
    int                gv;

    always_comb begin
        st_d     = st_q;
        sel      = cfg_sel_e'(cfg_sel_i);
        ci       = int'(cfg_idx_i);
        ack_take = ack_i && st_q.irq;
        clr_src  = '0;
        clr_trap = '0;
        gv       = int'(st_q.vnum);

        if (cfg_wr_i && (ci < N_SRC)) begin
            case (sel)
                SEL_PRIO: st_d.prio[ci] = cfg_data_i;
                SEL_EN:   st_d.en[ci]   = cfg_data_i[0];
                SEL_CLR:  clr_src[ci]   = cfg_data_i[0];
                SEL_ALT:  st_d.alt      = cfg_data_i[0];
                default:  ;
            endcase
        end

        if (ack_take) begin
            if (gv < N_TRAP) clr_trap[gv] = 1'b1;
            else if (gv - N_TRAP < N_SRC) clr_src[gv - N_TRAP] = 1'b1;
            st_d.gnum = st_q.vnum;
            st_d.glvl = st_q.lvl;
        end

        // a new request in the same cycle outlives any clear
        st_d.flag  = (st_q.flag & ~clr_src) | src_req_i;
        st_d.tflag = (st_q.tflag & ~clr_trap) | trap_req_i;

        st_d.irq  = win_valid && !ack_take;
        st_d.vnum = win_num;
        st_d.addr = win_addr;
        st_d.lvl  = win_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ri = int'(rd_idx_i);
        if (ri < N_SRC) rd_data_o = {st_q.flag[ri], st_q.en[ri], st_q.prio[ri]};
        else            rd_data_o = '0;
    end

    assign irq_o       = st_q.irq;
    assign vec_num_o   = st_q.vnum;
    assign vec_addr_o  = st_q.addr;
    assign irq_lvl_o   = st_q.lvl;
    assign grant_num_o = st_q.gnum;
    assign grant_lvl_o = st_q.glvl;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
    parameter int N_TRAP = 8,
    parameter int VN_W   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      cpu_lvl_i,
    input logic            irq_o,
    input logic [VN_W-1:0] vec_num_o,
    input logic [3:0]      irq_lvl_o,
    input logic            ack_i,
    input logic [VN_W-1:0] grant_num_o,
    input logic [3:0]      grant_lvl_o
);
    localparam logic [VN_W-1:0] TRAP_LIM = VN_W'(N_TRAP);

    assert_trap_lvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (vec_num_o < TRAP_LIM)) |-> (irq_lvl_o == 4'd8));

    assert_mask_lvl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (vec_num_o >= TRAP_LIM)) |-> ((irq_lvl_o >= 4'd1) && (irq_lvl_o <= 4'd7)));

    assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_lvl_o > $past(cpu_lvl_i)));

    assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !irq_o);

    assert_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> ((grant_num_o == $past(vec_num_o)) && (grant_lvl_o == $past(irq_lvl_o))));

    assert_grant_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> ($stable(grant_num_o) && $stable(grant_lvl_o)));
endmodule

bind pvic_top pvic_chk #(.N_TRAP(N_TRAP), .VN_W(VN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_lvl_i   (cpu_lvl_i),
    .irq_o       (irq_o),
    .vec_num_o   (vec_num_o),
    .irq_lvl_o   (irq_lvl_o),
    .ack_i       (ack_i),
    .grant_num_o (grant_num_o),
    .grant_lvl_o (grant_lvl_o)
);

// File: tb/sim_pvic_top.sv
`timescale 1ns/1ps
module sim_pvic_top;
    localparam int N_SRC = 16;
    localparam int N_TRAP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = '0;
    logic [7:0]  trap_req = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [3:0]  cfg_idx = '0;
    logic [2:0]  cfg_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [4:0]  rd_data;
    logic [3:0]  cpu_lvl = '0;
    logic        irq;
    logic [4:0]  vnum;
    logic [23:0] vaddr;
    logic [3:0]  vlvl;
    logic        ack = 1'b0;
    logic [4:0]  gnum;
    logic [3:0]  glvl;

    always #10 clk = ~clk;

    pvic_top u0 (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .trap_req_i(trap_req),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data), .cpu_lvl_i(cpu_lvl),
        .irq_o(irq), .vec_num_o(vnum), .vec_addr_o(vaddr), .irq_lvl_o(vlvl),
        .ack_i(ack), .grant_num_o(gnum), .grant_lvl_o(glvl)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        bit    irq;
        int    num;
        int    addr;
        int    lvl;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    event smp_ev;

    // monitor: pops one expected item per sample and compares the outputs
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s irq act=%0b exp=%0b", e.tag, irq, e.irq);
                end else if (e.irq && (int'(vnum) != e.num || int'(vaddr) != e.addr || int'(vlvl) != e.lvl)) begin
                    n_fail++;
                    $display("FAIL %s vec act=%0d/0x%06h/%0d exp=%0d/0x%06h/%0d",
                             e.tag, vnum, vaddr, vlvl, e.num, e.addr, e.lvl);
                end
            end
        end
    end

    task automatic expect_out(input bit i, input int n, input int a, input int l, input string tag);
        exp_t e;
        e.irq = i; e.num = n; e.addr = a; e.lvl = l; e.tag = tag;
        exp_q.push_back(e);
        ->smp_ev;
        #1;
    endtask

    task automatic chk_val(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic cfg(input int sel, input int idx, input int data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_idx = 4'(idx); cfg_data = 3'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] s, input logic [7:0] t);
        @(negedge clk);
        src_req = s; trap_req = t;
        @(negedge clk);
        src_req = '0; trap_req = '0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input int exp, input string tag);
        rd_idx = 4'(idx);
        #1;
        chk_val(tag, int'(rd_data), exp);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        expect_out(0, 0, 0, 0, "R1 reset irq");
        rd_chk(0, 0, "R1 reset src0");
        rd_chk(15, 0, "R1 reset src15");

        // R8/R7 single source, latency
        cfg(0, 3, 4); cfg(1, 3, 1);
        pulse(16'h0008, 8'h00);
        expect_out(0, 0, 0, 0, "R8 no request yet");
        cyc();
        expect_out(1, 11, 'h1A, 4, "R7 R8 src3 vector");

        // R9 ack
        do_ack();
        expect_out(0, 0, 0, 0, "R9 irq drops after ack");
        chk_val("R9 grant num", int'(gnum), 11);
        chk_val("R9 grant lvl", int'(glvl), 4);
        rd_chk(3, 5'b0_1_100, "R9 flag cleared by ack");
        cyc();
        expect_out(0, 0, 0, 0, "R9 nothing pending");

        // R4 level then index
        cfg(0, 1, 2); cfg(1, 1, 1);
        cfg(0, 2, 6); cfg(1, 2, 1);
        cfg(0, 5, 6); cfg(1, 5, 1);
        pulse(16'h0026, 8'h00);
        cyc();
        expect_out(1, 10, 'h18, 6, "R4 tie lowest index");
        do_ack(); cyc();
        expect_out(1, 13, 'h1E, 6, "R4 second of tie");
        do_ack(); cyc();
        expect_out(1, 9, 'h16, 2, "R4 lowest level last");
        do_ack(); cyc();

        // R6 / R10 preemption threshold
        cpu_lvl = 4'd5;
        pulse(16'h0008, 8'h00);
        cyc();
        expect_out(0, 0, 0, 0, "R6 level 4 below cpu 5");
        cfg(0, 3, 5);
        cyc();
        expect_out(0, 0, 0, 0, "R6 equal level waits");
        cfg(0, 3, 6);
        cyc();
        expect_out(1, 11, 'h1A, 6, "R10 raised level preempts");
        do_ack(); cyc();
        cpu_lvl = 4'd0;

        // R3 masking
        cfg(0, 7, 7);
        pulse(16'h0080, 8'h00);
        cyc();
        expect_out(0, 0, 0, 0, "R3 disabled source silent");
        rd_chk(7, 5'b1_0_111, "R3 disabled flag pending");
        cfg(1, 7, 1);
        cyc();
        expect_out(1, 15, 'h22, 7, "R3 enable releases");
        cfg(2, 7, 1);
        cyc();
        expect_out(0, 0, 0, 0, "R2 w1c clears request");
        rd_chk(7, 5'b0_1_111, "R2 flag cleared by write");

        // R9 ack with irq low is ignored
        cfg(1, 7, 0);
        pulse(16'h0080, 8'h00);
        do_ack();
        rd_chk(7, 5'b1_0_111, "R9 idle ack keeps flag");
        chk_val("R9 idle ack grant num", int'(gnum), 11);
        chk_val("R9 idle ack grant lvl", int'(glvl), 6);
        cfg(2, 7, 1);

        // R3 level zero
        cfg(1, 8, 1);
        pulse(16'h0100, 8'h00);
        cyc();
        expect_out(0, 0, 0, 0, "R3 level zero silent");
        rd_chk(8, 5'b1_1_000, "R3 level zero flag pending");
        cfg(2, 8, 1);

        // R2 set beats clear
        cfg(0, 9, 3); cfg(1, 9, 1);
        @(negedge clk);
        src_req = 16'h0200; cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_idx = 4'd9; cfg_data = 3'd1;
        @(negedge clk);
        src_req = '0; cfg_wr = 1'b0;
        rd_chk(9, 5'b1_1_011, "R2 set wins over clear");
        cyc();
        expect_out(1, 17, 'h26, 3, "R2 src9 request");
        do_ack(); cyc();

        // R5 traps
        cpu_lvl = 4'd7;
        cfg(0, 0, 7); cfg(1, 0, 1);
        pulse(16'h0001, 8'h24);
        cyc();
        expect_out(1, 2, 'h08, 8, "R5 lowest trap first");
        do_ack(); cyc();
        expect_out(1, 5, 'h0E, 8, "R5 second trap");
        do_ack(); cyc();
        expect_out(0, 0, 0, 0, "R6 level 7 vs cpu 7");
        cpu_lvl = 4'd0;
        cyc(); cyc();
        expect_out(1, 8, 'h14, 7, "R7 source 0 at 0x14");
        do_ack(); cyc();

        // R7 alternate table
        cfg(3, 0, 1);
        cfg(0, 15, 1); cfg(1, 15, 1);
        pulse(16'h8000, 8'h00);
        cyc();
        expect_out(1, 23, 'h132, 1, "R7 alt table source 15");
        do_ack(); cyc();
        pulse(16'h0000, 8'h01);
        cyc();
        expect_out(1, 0, 'h104, 8, "R7 alt table trap 0");
        do_ack(); cyc();
        expect_out(0, 0, 0, 0, "R9 all served");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule